// File: doc/BRIEF.md
# PD Transmit Message Byte Sequencer

This block drives the transmit side of a USB Power Delivery message at the byte level. The host presents a 20-bit start-of-packet ordered set, a payload byte count and a transmit mode, then pulses a send command. The sequencer first hands the four 5-bit K-codes to a downstream encoder, earliest K-code from the low bits. It then asks the host for payload bytes one at a time and forwards each to the encoder, and finally strobes end-of-message. CRC, 4b5b coding and line coding live downstream. They see only a ready/valid unit stream with a K-code marker and the end strobe.

A hard reset request has priority. If one arrives while a message is on its way out, that message is abandoned and flagged as aborted, and the hard-reset ordered set is sent in its place. A send issued while the receiver reports a busy line is dropped. The drop is reported only after the line has gone quiet. If the host falls behind while the encoder waits for a payload byte, the message ends with an underrun. All outcomes land in sticky status flags. Each flag is cleared by writing one to its clear bit, and a single maskable interrupt is formed from them.

Top module: `pd_tx_sequencer`

## Requirements
- R1: After a normal send on an idle line, the first four units out carry `out_kcode_o`=1 and, in `out_data_o[4:0]`, bits [4:0], [9:5], [14:10] and [19:15] of `ordset_i`, in that order. While `out_valid_o` is high and `out_ready_i` is low, the unit holds steady.
- R2: In mode 0 the payload count is taken from `paysz_i` when the send starts. That count covers header and data, with CRC excluded. After the K-codes, exactly that many bytes are forwarded with `out_kcode_o`=0, in write order. A count of zero ends the message right after the K-codes.
- R3: During the payload phase, `txreq_o` is high while no byte is buffered and bytes remain to be written. It drops in the cycle after a write is taken. It stays low once the last counted byte has been written. Writes while it is low are ignored.
- R4: `send_pend_o` and `hrst_pend_o` rise the cycle after `send_i` or `hrst_i` and clear by themselves as soon as the request starts or is dropped.
- R5: If the payload buffer is empty while `out_ready_i` stays high for UND_LIMIT cycles, flag bit 1 (underrun) is set. The message then ends with no end strobe and no sent flag.
- R6: A hard reset requested during a normal, cable-reset or test-carrier transmission sets flag bit 3 (abort) and never sets bit 0 (sent). The four K-codes of HRST_ORDSET follow, then the end strobe, then flag bit 4 (hard reset done).
- R7: A send while `line_busy_i` is high transmits nothing. Flag bit 2 (discard) is set only in the cycle after the line becomes idle again.
- R8: Flags stay set until a one is written to the matching `clr_i` bit. A set in the same cycle wins over the clear. `irq_o` is the OR over `{txreq_o, flags_o}` ANDed with `ien_i`, with `txreq_o` at `ien_i[5]`.
- R9: `mode_i` selects the message type: 0 for a normal packet, 1 for the CABLE_ORDSET K-codes only, 2 for BIST_BYTES test-carrier bytes of value BIST_PAT. Code 3 is ignored: the pending send clears, nothing is sent, and no flag is set.
- R10: `out_eom_o` is a one-cycle pulse in the cycle after the last unit of a completed message is accepted. The sent flag (bit 0), or the hard-reset-done flag (bit 4) for a hard reset, rises in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ordset_i | input | 20 | Ordered set for a normal message, earliest K-code in the low bits |
| paysz_i | input | 10 | Payload byte count for a normal message |
| mode_i | input | 2 | Transmit mode: 0 normal, 1 cable reset, 2 test carrier, 3 invalid |
| send_i | input | 1 | Send command pulse |
| hrst_i | input | 1 | Hard reset command pulse |
| data_wr_i | input | 1 | Host payload byte write strobe |
| data_i | input | 8 | Host payload byte |
| txreq_o | output | 1 | Payload byte requested |
| send_pend_o | output | 1 | Send command pending |
| hrst_pend_o | output | 1 | Hard reset command pending |
| line_busy_i | input | 1 | Receiver reports activity on the line |
| out_valid_o | output | 1 | Unit valid toward the encoder |
| out_ready_i | input | 1 | Encoder accepts the unit |
| out_data_o | output | 8 | Unit: K-code in bits [4:0] or payload byte |
| out_kcode_o | output | 1 | Unit is a K-code |
| out_eom_o | output | 1 | End-of-message strobe |
| flags_o | output | 5 | Sticky flags: 0 sent, 1 underrun, 2 discard, 3 abort, 4 hard reset done |
| clr_i | input | 5 | Write-one clear per flag |
| ien_i | input | 6 | Interrupt enables; bits 4:0 for flags, bit 5 for the data request |
| irq_o | output | 1 | Interrupt |

## Verification
The bench builds the block with UND_LIMIT reduced to 4 and BIST_BYTES reduced to 5. With these values the underrun timeout and the full test-carrier burst both finish within a few dozen cycles, so each scenario can check that no extra units or strobes follow. The ordered-set parameters keep their hard-reset and cable-reset defaults, so the bench compares the K-code streams against those known patterns. The backpressure and hard-reset scenarios hold the encoder's ready low, which freezes the sequencer in its K-code phase at a chosen moment.

// File: rtl/pd_tx_pkg.sv
package pd_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KCODE,
      ST_PAYLOAD,
      ST_BIST,
      ST_DISC
   } tx_state_e;

   localparam logic [1:0] MODE_MSG   = 2'd0;
   localparam logic [1:0] MODE_CABLE = 2'd1;
   localparam logic [1:0] MODE_BIST  = 2'd2;
   localparam logic [1:0] MODE_BAD   = 2'd3;

   localparam int FLG_SENT  = 0;
   localparam int FLG_UNDER = 1;
   localparam int FLG_DISC  = 2;
   localparam int FLG_ABORT = 3;
   localparam int FLG_HDONE = 4;
   localparam int NUM_FLAGS = 5;

endpackage

// File: rtl/pd_tx_kshift.sv
module pd_tx_kshift #(
   parameter int K_W   = 5,
   parameter int NUM_K = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load_i,
   input  logic [K_W*NUM_K-1:0]   ord_i,
   input  logic                   step_i,
   output logic [K_W-1:0]         kcode_o,
   output logic                   last_o
);
   localparam int ORD_W = K_W * NUM_K;
   localparam int IW    = (NUM_K > 1) ? $clog2(NUM_K) : 1;

   logic [ORD_W-1:0] sh_q;
   logic [IW-1:0]    idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= ord_i;
         idx_q <= '0;
      end else if (step_i) begin
         sh_q  <= sh_q >> K_W;
         idx_q <= idx_q + 1'b1;
      end
   end

   assign kcode_o = sh_q[K_W-1:0];
   assign last_o  = (idx_q == IW'(NUM_K - 1));
endmodule

// File: rtl/pd_tx_paybuf.sv
module pd_tx_paybuf #(
   parameter int CNT_W     = 10,
   parameter int DATA_W    = 8,
   parameter int UND_LIMIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              active_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              take_i,
   input  logic              ready_i,
   output logic              full_o,
   output logic [DATA_W-1:0] byte_o,
   output logic              rem_zero_o,
   output logic              req_o,
   output logic              underrun_o
);
   logic [CNT_W-1:0]  rem_q;
   logic              full_q;
   logic [DATA_W-1:0] byte_q;
   logic              wr_ok;

   assign req_o      = active_i && !full_q && (rem_q != '0);
   assign wr_ok      = req_o && wr_i;
   assign full_o     = full_q;
   assign byte_o     = byte_q;
   assign rem_zero_o = (rem_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q  <= '0;
         full_q <= 1'b0;
         byte_q <= '0;
      end else if (start_i) begin
         rem_q  <= cnt_i;
         full_q <= 1'b0;
      end else if (wr_ok) begin
         byte_q <= wdata_i;
         full_q <= 1'b1;
         rem_q  <= rem_q - 1'b1;
      end else if (take_i) begin
         full_q <= 1'b0;
      end
   end

   generate
      if (UND_LIMIT > 0) begin : g_und
         localparam int UW = (UND_LIMIT > 1) ? $clog2(UND_LIMIT) : 1;
         logic [UW-1:0] wait_q;
         logic          starving;
         assign starving   = req_o && ready_i && !wr_i;
         assign underrun_o = starving && (wait_q == UW'(UND_LIMIT - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      wait_q <= '0;
            else if (!starving || underrun_o) wait_q <= '0;
            else                             wait_q <= wait_q + 1'b1;
         end
      end else begin : g_no_und
         assign underrun_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pd_tx_flags.sv
module pd_tx_flags #(
   parameter int NF = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set_i,
   input  logic [NF-1:0] clr_i,
   input  logic          txreq_i,
   input  logic [NF:0]   ien_i,
   output logic [NF-1:0] flags_o,
   output logic          irq_o
);
   logic [NF-1:0] flags_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (flags_q & ~clr_i) | set_i;
   end

   assign flags_o = flags_q;
   assign irq_o   = |({txreq_i, flags_q} & ien_i);
endmodule

// File: rtl/pd_tx_sequencer.sv
module pd_tx_sequencer
   import pd_tx_pkg::*;
#(
   parameter int                 K_W          = 5,
   parameter int                 NUM_K        = 4,
   parameter int                 CNT_W        = 10,
   parameter int                 DATA_W       = 8,
   parameter int                 UND_LIMIT    = 16,
   parameter int                 BIST_BYTES   = 64,
   parameter logic [DATA_W-1:0]  BIST_PAT     = 8'hAA,
   parameter logic [K_W*NUM_K-1:0] HRST_ORDSET  = {5'b11001, 5'b00111, 5'b00111, 5'b00111},
   parameter logic [K_W*NUM_K-1:0] CABLE_ORDSET = {5'b00110, 5'b00111, 5'b11000, 5'b00111}
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [K_W*NUM_K-1:0]   ordset_i,
   input  logic [CNT_W-1:0]       paysz_i,
   input  logic [1:0]             mode_i,
   input  logic                   send_i,
   input  logic                   hrst_i,
   input  logic                   data_wr_i,
   input  logic [DATA_W-1:0]      data_i,
   output logic                   txreq_o,
   output logic                   send_pend_o,
   output logic                   hrst_pend_o,
   input  logic                   line_busy_i,
   output logic                   out_valid_o,
   input  logic                   out_ready_i,
   output logic [DATA_W-1:0]      out_data_o,
   output logic                   out_kcode_o,
   output logic                   out_eom_o,
   output logic [NUM_FLAGS-1:0]   flags_o,
   input  logic [NUM_FLAGS-1:0]   clr_i,
   input  logic [NUM_FLAGS:0]     ien_i,
   output logic                   irq_o
);
   localparam int ORD_W = K_W * NUM_K;
   localparam int BW    = $clog2(BIST_BYTES + 1);

   generate
      if (DATA_W <= K_W)  begin : g_bad_width $error("DATA_W must exceed K_W"); end
      if (NUM_K < 2)      begin : g_bad_numk  $error("NUM_K must be at least 2"); end
      if (BIST_BYTES < 1) begin : g_bad_bist  $error("BIST_BYTES must be at least 1"); end
   endgenerate

   tx_state_e        st_q, st_d;
   logic             send_pend_q, hrst_pend_q, is_hrst_q, is_hrst_d, eom_q, eom_d;
   logic             send_clr, hrst_clr;
   logic [BW-1:0]    bist_q, bist_d;
   logic             k_load, k_step, k_last;
   logic [ORD_W-1:0] k_ord;
   logic [K_W-1:0]   kcode;
   logic             pay_start, pay_full, pay_rem_zero, pay_under;
   logic [CNT_W-1:0] pay_cnt;
   logic [DATA_W-1:0] pay_byte;
   logic [NUM_FLAGS-1:0] flag_set;
   logic             accept, preempt;

   pd_tx_kshift #(.K_W(K_W), .NUM_K(NUM_K)) u_kshift (
      .clk(clk), .rst_n(rst_n), .load_i(k_load), .ord_i(k_ord),
      .step_i(k_step), .kcode_o(kcode), .last_o(k_last));

   pd_tx_paybuf #(.CNT_W(CNT_W), .DATA_W(DATA_W), .UND_LIMIT(UND_LIMIT)) u_paybuf (
      .clk(clk), .rst_n(rst_n), .start_i(pay_start), .cnt_i(pay_cnt),
      .active_i(st_q == ST_PAYLOAD), .wr_i(data_wr_i), .wdata_i(data_i),
      .take_i(accept && (st_q == ST_PAYLOAD)), .ready_i(out_ready_i),
      .full_o(pay_full), .byte_o(pay_byte), .rem_zero_o(pay_rem_zero),
      .req_o(txreq_o), .underrun_o(pay_under));

   pd_tx_flags #(.NF(NUM_FLAGS)) u_flags (
      .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(clr_i),
      .txreq_i(txreq_o), .ien_i(ien_i), .flags_o(flags_o), .irq_o(irq_o));

   assign out_valid_o = (st_q == ST_KCODE) || (st_q == ST_BIST) ||
                        ((st_q == ST_PAYLOAD) && pay_full);
   assign out_kcode_o = (st_q == ST_KCODE);
   assign out_data_o  = (st_q == ST_KCODE) ? {{(DATA_W-K_W){1'b0}}, kcode} :
                        (st_q == ST_BIST)  ? BIST_PAT : pay_byte;
   assign accept      = out_valid_o && out_ready_i;
   assign preempt     = hrst_pend_q && !is_hrst_q &&
                        ((st_q == ST_KCODE) || (st_q == ST_PAYLOAD) || (st_q == ST_BIST));

   always_comb begin
      st_d      = st_q;
      is_hrst_d = is_hrst_q;
      bist_d    = bist_q;
      eom_d     = 1'b0;
      send_clr  = 1'b0;
      hrst_clr  = 1'b0;
      k_load    = 1'b0;
      k_ord     = HRST_ORDSET;
      k_step    = 1'b0;
      pay_start = 1'b0;
      pay_cnt   = '0;
      flag_set  = '0;
      if (preempt) begin
         flag_set[FLG_ABORT] = 1'b1;
         hrst_clr  = 1'b1;
         k_load    = 1'b1;
         pay_start = 1'b1;
         is_hrst_d = 1'b1;
         st_d      = ST_KCODE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (hrst_pend_q && !line_busy_i) begin
                  hrst_clr  = 1'b1;
                  k_load    = 1'b1;
                  pay_start = 1'b1;
                  is_hrst_d = 1'b1;
                  st_d      = ST_KCODE;
               end else if (send_pend_q && !hrst_pend_q) begin
                  send_clr = 1'b1;
                  if (mode_i == MODE_BAD) begin
                     st_d = ST_IDLE;
                  end else if (line_busy_i) begin
                     st_d = ST_DISC;
                  end else begin
                     is_hrst_d = 1'b0;
                     pay_start = 1'b1;
                     if (mode_i == MODE_BIST) begin
                        bist_d = '0;
                        st_d   = ST_BIST;
                     end else begin
                        k_load  = 1'b1;
                        k_ord   = (mode_i == MODE_CABLE) ? CABLE_ORDSET : ordset_i;
                        pay_cnt = (mode_i == MODE_MSG) ? paysz_i : '0;
                        st_d    = ST_KCODE;
                     end
                  end
               end
            end
            ST_KCODE: begin
               if (accept) begin
                  k_step = 1'b1;
                  if (k_last) begin
                     if (pay_rem_zero) begin
                        eom_d = 1'b1;
                        flag_set[is_hrst_q ? FLG_HDONE : FLG_SENT] = 1'b1;
                        st_d  = ST_IDLE;
                     end else begin
                        st_d  = ST_PAYLOAD;
                     end
                  end
               end
            end
            ST_PAYLOAD: begin
               if (pay_under) begin
                  flag_set[FLG_UNDER] = 1'b1;
                  st_d = ST_IDLE;
               end else if (accept && pay_rem_zero) begin
                  eom_d = 1'b1;
                  flag_set[FLG_SENT] = 1'b1;
                  st_d  = ST_IDLE;
               end
            end
            ST_BIST: begin
               if (accept) begin
                  if (bist_q == BW'(BIST_BYTES - 1)) begin
                     eom_d = 1'b1;
                     flag_set[FLG_SENT] = 1'b1;
                     st_d  = ST_IDLE;
                  end else begin
                     bist_d = bist_q + 1'b1;
                  end
               end
            end
            ST_DISC: begin
               if (!line_busy_i) begin
                  flag_set[FLG_DISC] = 1'b1;
                  st_d = ST_IDLE;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         send_pend_q <= 1'b0;
         hrst_pend_q <= 1'b0;
         is_hrst_q   <= 1'b0;
         eom_q       <= 1'b0;
         bist_q      <= '0;
      end else begin
         st_q        <= st_d;
         send_pend_q <= send_i | (send_pend_q & ~send_clr);
         hrst_pend_q <= hrst_i | (hrst_pend_q & ~hrst_clr);
         is_hrst_q   <= is_hrst_d;
         eom_q       <= eom_d;
         bist_q      <= bist_d;
      end
   end

   assign send_pend_o = send_pend_q;
   assign hrst_pend_o = hrst_pend_q;
   assign out_eom_o   = eom_q;
endmodule

// File: rtl/pd_tx_seq_chk.sv
module pd_tx_seq_chk #(
   parameter int DATA_W = 8,
   parameter int NF     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              idle,
   input logic              send_i,
   input logic              send_pend_o,
   input logic              hrst_pend_o,
   input logic              data_wr_i,
   input logic              txreq_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic [DATA_W-1:0] out_data_o,
   input logic              out_eom_o,
   input logic [NF-1:0]     flags_o,
   input logic [NF-1:0]     clr_i,
   input logic              line_busy_i
);
   AST_CMD_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && send_pend_o && !hrst_pend_o && !send_i) |=> !send_pend_o); // R4
   AST_REQ_DROPS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && txreq_o) |=> !txreq_o); // R3
   AST_UNIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i && !hrst_pend_o) |=> (out_valid_o && $stable(out_data_o))); // R1
   AST_EOM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_eom_o |=> !out_eom_o); // R10
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flags_o) & ~$past(clr_i) & ~flags_o) == '0)); // R8
   AST_DISC_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[2]) |-> !$past(line_busy_i)); // R7
endmodule

bind pd_tx_sequencer pd_tx_seq_chk #(.DATA_W(DATA_W), .NF(pd_tx_pkg::NUM_FLAGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .idle(st_q == pd_tx_pkg::ST_IDLE), .send_i(send_i),
   .send_pend_o(send_pend_o), .hrst_pend_o(hrst_pend_o), .data_wr_i(data_wr_i),
   .txreq_o(txreq_o), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
   .out_data_o(out_data_o), .out_eom_o(out_eom_o), .flags_o(flags_o),
   .clr_i(clr_i), .line_busy_i(line_busy_i));

// File: tb/pd_tx_sequencer_tb.sv
module pd_tx_sequencer_tb;
   localparam logic [19:0] HRST_OS  = {5'b11001, 5'b00111, 5'b00111, 5'b00111};
   localparam logic [19:0] CABLE_OS = {5'b00110, 5'b00111, 5'b11000, 5'b00111};
   localparam int NBIST = 5;

   logic        clk = 0;
   logic        rst_n = 0;
   logic [19:0] ordset_i = '0;
   logic [9:0]  paysz_i = '0;
   logic [1:0]  mode_i = '0;
   logic        send_i = 0, hrst_i = 0, data_wr_i = 0;
   logic [7:0]  data_i = '0;
   logic        txreq_o, send_pend_o, hrst_pend_o;
   logic        line_busy_i = 0;
   logic        out_valid_o, out_ready_i = 1, out_kcode_o, out_eom_o, irq_o;
   logic [7:0]  out_data_o;
   logic [4:0]  flags_o;
   logic [4:0]  clr_i = '0;
   logic [5:0]  ien_i = '0;

   int checks = 0, errors = 0, eoms = 0;
   logic [7:0] cap_d[$];
   logic       cap_k[$];
   logic [7:0] fq[$];

   always #4 clk = ~clk;

   pd_tx_sequencer #(.UND_LIMIT(4), .BIST_BYTES(NBIST)) u_dut (
      .clk(clk), .rst_n(rst_n), .ordset_i(ordset_i), .paysz_i(paysz_i), .mode_i(mode_i),
      .send_i(send_i), .hrst_i(hrst_i), .data_wr_i(data_wr_i), .data_i(data_i),
      .txreq_o(txreq_o), .send_pend_o(send_pend_o), .hrst_pend_o(hrst_pend_o),
      .line_busy_i(line_busy_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
      .out_data_o(out_data_o), .out_kcode_o(out_kcode_o), .out_eom_o(out_eom_o),
      .flags_o(flags_o), .clr_i(clr_i), .ien_i(ien_i), .irq_o(irq_o));

   always @(posedge clk) begin
      if (rst_n && out_valid_o && out_ready_i) begin
         cap_d.push_back(out_data_o);
         cap_k.push_back(out_kcode_o);
      end
      if (rst_n && out_eom_o) eoms++;
   end

   always @(negedge clk) begin
      if (txreq_o && fq.size() > 0) begin
         data_wr_i = 1;
         data_i    = fq.pop_front();
      end else begin
         data_wr_i = 0;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_send();
      send_i = 1; cyc(1); send_i = 0;
   endtask

   task automatic pulse_hrst();
      hrst_i = 1; cyc(1); hrst_i = 0;
   endtask

   task automatic clear_all();
      clr_i = 5'h1F; cyc(1); clr_i = '0;
      cap_d.delete(); cap_k.delete(); eoms = 0;
   endtask

   task automatic chk_kcodes(string tag, int base, logic [19:0] os);
      for (int i = 0; i < 4; i++) begin
         chk({tag, " kcode value"}, (base + i < cap_d.size()) ? 32'(cap_d[base+i]) : 32'hDEAD,
             32'((os >> (5*i)) & 20'h1F));
         chk({tag, " kcode marker"}, (base + i < cap_k.size()) ? 32'(cap_k[base+i]) : 32'hDEAD, 1);
      end
   endtask

   task automatic t_reset();
      chk("R8 reset flags", flags_o, 0);
      chk("R1 reset valid", out_valid_o, 0);
      chk("R8 reset irq", irq_o, 0);
      chk("R4 reset pend", {send_pend_o, hrst_pend_o}, 0);
      chk("R3 reset txreq", txreq_o, 0);
   endtask

   task automatic t_normal();
      logic [7:0] b[3] = '{8'h11, 8'h5A, 8'hC3};
      ordset_i = 20'h3A5C9; paysz_i = 3; mode_i = 0;
      for (int i = 0; i < 3; i++) fq.push_back(b[i]);
      send_i = 1; cyc(1); send_i = 0;
      chk("R4 send pending", send_pend_o, 1);
      cyc(1);
      chk("R4 send self-clear", send_pend_o, 0);
      cyc(40);
      chk("R2 unit count", cap_d.size(), 7);
      chk_kcodes("R1 normal", 0, 20'h3A5C9);
      for (int i = 0; i < 3; i++) begin
         chk("R2 payload byte", (4 + i < cap_d.size()) ? 32'(cap_d[4+i]) : 32'hDEAD, 32'(b[i]));
         chk("R2 payload marker", (4 + i < cap_k.size()) ? 32'(cap_k[4+i]) : 32'hDEAD, 0);
      end
      chk("R10 one eom", eoms, 1);
      chk("R10 sent flag", flags_o, 5'b00001);
      chk("R3 txreq low after last", txreq_o, 0);
      clear_all();
   endtask

   task automatic t_zero_payload();
      ordset_i = 20'h0F0F1; paysz_i = 0; mode_i = 0;
      pulse_send(); cyc(20);
      chk("R2 zero payload units", cap_d.size(), 4);
      chk_kcodes("R2 zero payload", 0, 20'h0F0F1);
      chk("R10 zero payload eom", eoms, 1);
      chk("R2 zero payload sent", flags_o, 5'b00001);
      clear_all();
   endtask

   task automatic t_backpressure();
      ordset_i = 20'hB1234; paysz_i = 2; mode_i = 0;
      fq.push_back(8'h77); fq.push_back(8'h88);
      pulse_send();
      for (int i = 0; i < 60; i++) begin
         out_ready_i = ~out_ready_i; cyc(1);
      end
      out_ready_i = 1; cyc(10);
      chk("R1 backpressure count", cap_d.size(), 6);
      chk_kcodes("R1 backpressure", 0, 20'hB1234);
      chk("R2 backpressure b0", (cap_d.size() > 4) ? 32'(cap_d[4]) : 32'hDEAD, 8'h77);
      chk("R2 backpressure b1", (cap_d.size() > 5) ? 32'(cap_d[5]) : 32'hDEAD, 8'h88);
      chk("R10 backpressure sent", flags_o, 5'b00001);
      clear_all();
   endtask

   task automatic t_underrun();
      ordset_i = 20'h12345; paysz_i = 3; mode_i = 0;
      fq.push_back(8'h42);
      pulse_send(); cyc(40);
      chk("R5 underrun units", cap_d.size(), 5);
      chk("R5 underrun flag only", flags_o, 5'b00010);
      chk("R5 underrun no eom", eoms, 0);
      chk("R5 idle after underrun", {out_valid_o, txreq_o}, 0);
      clear_all();
   endtask

   task automatic t_discard();
      ordset_i = 20'h54321; paysz_i = 0; mode_i = 0;
      line_busy_i = 1;
      pulse_send(); cyc(10);
      chk("R4 pend cleared on discard", send_pend_o, 0);
      chk("R7 no flag while busy", flags_o, 0);
      line_busy_i = 0; cyc(1);
      chk("R7 discard flag after idle", flags_o, 5'b00100);
      cyc(10);
      chk("R7 nothing sent", cap_d.size(), 0);
      clear_all();
   endtask

   task automatic t_preempt();
      ordset_i = 20'h2468A; paysz_i = 2; mode_i = 0;
      out_ready_i = 0;
      pulse_send(); cyc(5);
      pulse_hrst(); cyc(3);
      chk("R6 abort flag", flags_o, 5'b01000);
      chk("R4 hrst self-clear", hrst_pend_o, 0);
      out_ready_i = 1; cyc(20);
      chk("R6 hard reset units", cap_d.size(), 4);
      chk_kcodes("R6 hard reset", 0, HRST_OS);
      chk("R6 abort and done, no sent", flags_o, 5'b11000);
      chk("R10 hard reset eom", eoms, 1);
      clear_all();
   endtask

   task automatic t_modes();
      mode_i = 3; pulse_send(); cyc(10);
      chk("R9 invalid mode nothing sent", cap_d.size(), 0);
      chk("R9 invalid mode no flag", flags_o, 0);
      chk("R9 invalid mode pend cleared", send_pend_o, 0);
      mode_i = 1; paysz_i = 7; pulse_send(); cyc(20);
      chk("R9 cable units", cap_d.size(), 4);
      chk_kcodes("R9 cable", 0, CABLE_OS);
      chk("R9 cable sent", flags_o, 5'b00001);
      clear_all();
      mode_i = 2; pulse_send(); cyc(20);
      chk("R9 bist units", cap_d.size(), NBIST);
      for (int i = 0; i < NBIST; i++) begin
         chk("R9 bist pattern", (i < cap_d.size()) ? 32'(cap_d[i]) : 32'hDEAD, 8'hAA);
         chk("R9 bist not kcode", (i < cap_k.size()) ? 32'(cap_k[i]) : 32'hDEAD, 0);
      end
      chk("R9 bist sent", flags_o, 5'b00001);
      clear_all();
      mode_i = 0;
   endtask

   task automatic t_irq();
      ordset_i = 20'h11111; paysz_i = 2; mode_i = 0;
      ien_i = 6'b100000;
      pulse_send();
      for (int i = 0; i < 50 && !txreq_o; i++) cyc(1);
      out_ready_i = 0;
      chk("R3 txreq in payload", txreq_o, 1);
      chk("R8 irq from txreq", irq_o, 1);
      data_i = 8'h99; data_wr_i = 1; // feeder overrides at next negedge only if queue non-empty
      fq.push_back(8'h01); fq.push_back(8'h02);
      cyc(1);
      chk("R3 txreq drops after write", txreq_o, 0);
      out_ready_i = 1; cyc(30);
      chk("R8 sent with txreq irq", flags_o, 5'b00001);
      chk("R8 txreq masked off", irq_o, 0);
      ien_i = 6'b000001; cyc(1);
      chk("R8 irq from sent", irq_o, 1);
      clr_i = 5'b00010; cyc(1); clr_i = '0;
      chk("R8 other clear keeps flag", flags_o, 5'b00001);
      clr_i = 5'b00001; cyc(1); clr_i = '0;
      chk("R8 clear by write one", flags_o, 0);
      chk("R8 irq low after clear", irq_o, 0);
      ien_i = '0;
      clear_all();
   endtask

   initial begin
      cyc(3);
      t_reset();
      rst_n = 1; cyc(2);
      t_normal();
      t_zero_payload();
      t_backpressure();
      t_underrun();
      t_discard();
      t_preempt();
      t_modes();
      t_irq();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule